// File: doc/BRIEF.md
# Machine-Mode Trap and Return Controller

This block sits next to a small core that runs in either user or machine privilege. When the core reports a synchronous exception, the block records the faulting PC, the cause code and a trap value. It saves the interrupt-enable bit and the previous privilege in its status word and switches to machine mode. It also gives the core the handler address as the next PC. When the core executes a machine return, the block restores the interrupt enable and the privilege from the saved fields and gives the saved exception PC as the next PC.

The block also decodes two instruction words: the environment call and the machine return. It supplies the environment-call cause that matches the current privilege. A small write port loads the handler address and the exception PC, so the surrounding logic can set up a handler before traps arrive. All state changes happen on one rising clock edge. The next-PC output is combinational from the strobes and the stored registers.

Top module: `trap_ctrl`

## Requirements
- R1: Synchronous reset sets privilege to 2'b11 (machine) and clears the status word (MIE, MPIE and MPP = 2'b00). It also clears the exception PC, cause, trap value and handler address.
- R2: `is_ecall` is high exactly when `insn` equals 32'h0000_0073. `is_mret` is high exactly when `insn` equals 32'h3020_0073.
- R3: `ecall_cause` is 8 when privilege is 2'b00 (user) and 11 when privilege is 2'b11 (machine).
- R4: While `trap_valid` is high, `redirect` is high and `next_pc` equals `tvec`. At the following edge, `epc` takes `trap_pc`, `cause` takes `trap_cause` and privilege becomes 2'b11.
- R5: On a trap edge, the old MIE (status bit 3) is copied into MPIE (status bit 7) and MIE is cleared. The old privilege is written into MPP (status bits 12:11).
- R6: On a trap, `tval` takes `trap_badaddr` for the fault causes 0, 1, 2, 4, 5, 6, 7, 12, 13 and 15. For breakpoint (cause 3), `tval` takes `trap_pc`. For all other causes (8, 9, 10, 11, 14), `tval` is cleared to 0.
- R7: `internal_error` is high in a cycle where `trap_valid` is high, the cause is one of the R6 fault causes and `trap_badaddr_valid` is low. Such a trap still happens and loads `tval` with 0.
- R8: When `ret_valid` is high and `trap_valid` is low, `redirect` is high and `next_pc` equals `epc`. At the edge, MIE takes MPIE, MPIE becomes 1, privilege takes MPP and MPP becomes 2'b00.
- R9: When both strobes are high, only the trap takes effect.
- R10: When `csr_wr_en` is high, `csr_wr_data` is written at the edge: to `tvec` if `csr_wr_sel` is 0, or to `epc` if it is 1. A trap in the same cycle overrides a write to `epc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_valid | input | 1 | Exception strobe |
| trap_cause | input | CAUSE_W | Exception cause code |
| trap_pc | input | XLEN | PC of the faulting instruction |
| trap_badaddr | input | XLEN | Faulting address |
| trap_badaddr_valid | input | 1 | trap_badaddr is meaningful |
| ret_valid | input | 1 | Machine-return strobe |
| csr_wr_en | input | 1 | Register write enable |
| csr_wr_sel | input | 1 | 0 selects tvec, 1 selects epc |
| csr_wr_data | input | XLEN | Write data |
| insn | input | 32 | Instruction word to decode |
| is_ecall | output | 1 | insn is the environment call |
| is_mret | output | 1 | insn is the machine return |
| ecall_cause | output | CAUSE_W | Cause code for an environment call at the current privilege |
| redirect | output | 1 | next_pc is valid this cycle |
| next_pc | output | XLEN | Handler address or return address |
| internal_error | output | 1 | Fault cause without a bad address |
| priv | output | 2 | Current privilege |
| status | output | XLEN | Status word (MIE bit 3, MPIE bit 7, MPP bits 12:11) |
| epc | output | XLEN | Saved exception PC |
| cause | output | CAUSE_W | Saved cause |
| tval | output | XLEN | Saved trap value |
| tvec | output | XLEN | Handler address |

## Verification
A trap and a machine return can be requested in the same cycle, and a register write to the exception PC can land on the same edge as a trap. The bench produces these collisions both by random strobes and by directed cycles. It judges them against a reference model in which the trap alone updates status, privilege and the exception PC, while a handler-address write in the same cycle still takes effect.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_valid,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    trap_badaddr,
  input  logic               trap_badaddr_valid,
  input  logic               ret_valid,
  input  logic               csr_wr_en,
  input  logic               csr_wr_sel,
  input  logic [XLEN-1:0]    csr_wr_data,
  input  logic [31:0]        insn,
  output logic               is_ecall,
  output logic               is_mret,
  output logic [CAUSE_W-1:0] ecall_cause,
  output logic               redirect,
  output logic [XLEN-1:0]    next_pc,
  output logic               internal_error,
  output logic [1:0]         priv,
  output logic [XLEN-1:0]    status,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    tval,
  output logic [XLEN-1:0]    tvec
);
  localparam logic [1:0]  PRIV_U = 2'b00;
  localparam logic [1:0]  PRIV_M = 2'b11;
  localparam int          IE_BIT = 3;
  localparam int          PIE_BIT = 7;
  localparam int          PP_LO = 11;
  localparam logic [31:0] ECALL_WORD = 32'h0000_0073;
  localparam logic [31:0] MRET_WORD  = 32'h3020_0073;

  logic       ie_q, pie_q;
  logic [1:0] pp_q, priv_q;
  logic       addr_fault, brk, take_ret;
  logic [XLEN-1:0] tval_next;

  assign is_ecall    = (insn == ECALL_WORD);
  assign is_mret     = (insn == MRET_WORD);
  assign ecall_cause = (priv_q == PRIV_U) ? CAUSE_W'(8) : CAUSE_W'(11);

  always_comb begin
    case (trap_cause)
      CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(2), CAUSE_W'(4), CAUSE_W'(5),
      CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13), CAUSE_W'(15):
        addr_fault = 1'b1;
      default: addr_fault = 1'b0;
    endcase
  end

  assign brk            = (trap_cause == CAUSE_W'(3));
  assign internal_error = trap_valid & addr_fault & ~trap_badaddr_valid;
  assign take_ret       = ret_valid & ~trap_valid;
  assign tval_next      = addr_fault ? (trap_badaddr_valid ? trap_badaddr : '0)
                        : brk        ? trap_pc : '0;

  assign redirect = trap_valid | ret_valid;
  assign next_pc  = trap_valid ? tvec : ret_valid ? epc : '0;
  assign priv     = priv_q;

  always_comb begin
    status = '0;
    status[IE_BIT]         = ie_q;
    status[PIE_BIT]        = pie_q;
    status[PP_LO+1:PP_LO]  = pp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q <= PRIV_M;
      ie_q   <= 1'b0;
      pie_q  <= 1'b0;
      pp_q   <= PRIV_U;
      epc    <= '0;
      cause  <= '0;
      tval   <= '0;
      tvec   <= '0;
    end else begin
      if (csr_wr_en && !csr_wr_sel) tvec <= csr_wr_data;
      if (csr_wr_en && csr_wr_sel)  epc  <= csr_wr_data;
      if (trap_valid) begin
        epc    <= trap_pc;
        cause  <= trap_cause;
        tval   <= tval_next;
        pie_q  <= ie_q;
        ie_q   <= 1'b0;
        pp_q   <= priv_q;
        priv_q <= PRIV_M;
      end else if (take_ret) begin
        ie_q   <= pie_q;
        pie_q  <= 1'b1;
        priv_q <= (pp_q == PRIV_M) ? PRIV_M : PRIV_U;
        pp_q   <= PRIV_U;
      end
    end
  end
endmodule

module trap_ctrl_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               trap_valid,
  input logic               ret_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               is_ecall,
  input logic               is_mret,
  input logic               redirect,
  input logic [XLEN-1:0]    next_pc,
  input logic               internal_error,
  input logic [1:0]         priv,
  input logic [XLEN-1:0]    status,
  input logic [XLEN-1:0]    epc,
  input logic [XLEN-1:0]    tval,
  input logic [XLEN-1:0]    tvec
);
  assert_decode_excl_R2: assert property (@(posedge clk) !(is_ecall && is_mret));

  assert_trap_vector_R4: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (redirect && next_pc == tvec));

  assert_trap_machine_R4: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> priv == 2'b11);

  assert_trap_status_R5: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> (!status[3] && status[7] == $past(status[3])
                    && status[12:11] == $past(priv)));

  assert_ecall_tval_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_cause == CAUSE_W'(8)) |=> tval == '0);

  assert_ierr_needs_trap_R7: assert property (@(posedge clk) disable iff (rst)
    internal_error |-> trap_valid);

  assert_ret_status_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !trap_valid) |=> (status[7] && status[12:11] == 2'b00
                                    && status[3] == $past(status[7])));

  assert_ret_target_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !trap_valid) |-> next_pc == epc);
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_chk (
  .clk(clk), .rst(rst), .trap_valid(trap_valid), .ret_valid(ret_valid),
  .trap_cause(trap_cause), .is_ecall(is_ecall), .is_mret(is_mret),
  .redirect(redirect), .next_pc(next_pc), .internal_error(internal_error),
  .priv(priv), .status(status), .epc(epc), .tval(tval), .tvec(tvec)
);

// File: tb/test_trap_ctrl.sv
`timescale 1ns/1ps
module test_trap_ctrl;
  localparam int XLEN = 32;
  localparam int CW   = 4;

  logic clk = 0, rst = 1;
  logic trap_valid = 0, trap_badaddr_valid = 0, ret_valid = 0, csr_wr_en = 0, csr_wr_sel = 0;
  logic [CW-1:0] trap_cause = '0;
  logic [XLEN-1:0] trap_pc = '0, trap_badaddr = '0, csr_wr_data = '0;
  logic [31:0] insn = '0;
  logic is_ecall, is_mret, redirect, internal_error;
  logic [CW-1:0] ecall_cause, cause;
  logic [XLEN-1:0] next_pc, status, epc, tval, tvec;
  logic [1:0] priv;

  int errors = 0, checks = 0;

  logic [1:0] m_priv, m_pp;
  logic m_ie, m_pie;
  logic [XLEN-1:0] m_epc, m_tval, m_tvec;
  logic [CW-1:0] m_cause;

  always #2 clk = ~clk;

  trap_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) i_trap_ctrl (.*);

  function automatic bit is_fault(input logic [CW-1:0] c);
    return c inside {0, 1, 2, 4, 5, 6, 7, 12, 13, 15};
  endfunction

  function automatic logic [XLEN-1:0] exp_tval(input logic [CW-1:0] c, input logic v,
                                               input logic [XLEN-1:0] ba, input logic [XLEN-1:0] pc);
    if (is_fault(c)) return v ? ba : '0;
    if (c == 3) return pc;
    return '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_priv = 2'b11; m_pp = 2'b00; m_ie = 0; m_pie = 0;
    m_epc = '0; m_tval = '0; m_tvec = '0; m_cause = '0;
  endtask

  task automatic check_state(input string tag);
    logic [XLEN-1:0] st;
    st = '0; st[3] = m_ie; st[7] = m_pie; st[12:11] = m_pp;
    chk(priv == m_priv, {tag, " priv"}, 64'(priv), 64'(m_priv));
    chk(status == st, {tag, " status"}, 64'(status), 64'(st));
    chk(epc == m_epc, {tag, " epc"}, 64'(epc), 64'(m_epc));
    chk(cause == m_cause, {tag, " cause"}, 64'(cause), 64'(m_cause));
    chk(tval == m_tval, {tag, " tval"}, 64'(tval), 64'(m_tval));
    chk(tvec == m_tvec, {tag, " tvec"}, 64'(tvec), 64'(m_tvec));
  endtask

  // Inputs are already set (driven after a negedge); check comb outputs, step model and clock.
  task automatic cycle();
    logic [XLEN-1:0] xpc;
    #1;
    chk(is_ecall == (insn == 32'h0000_0073), "R2 is_ecall", 64'(is_ecall), 64'(insn == 32'h73));
    chk(is_mret == (insn == 32'h3020_0073), "R2 is_mret", 64'(is_mret), 64'(insn == 32'h30200073));
    chk(ecall_cause == ((m_priv == 2'b00) ? 4'd8 : 4'd11), "R3 ecall_cause", 64'(ecall_cause),
        64'((m_priv == 2'b00) ? 8 : 11));
    chk(redirect == (trap_valid | ret_valid), "R4 R8 redirect", 64'(redirect), 64'(trap_valid | ret_valid));
    xpc = trap_valid ? m_tvec : ret_valid ? m_epc : '0;
    if (trap_valid | ret_valid)
      chk(next_pc == xpc, trap_valid ? "R4 R9 next_pc" : "R8 next_pc", 64'(next_pc), 64'(xpc));
    chk(internal_error == (trap_valid && is_fault(trap_cause) && !trap_badaddr_valid),
        "R7 internal_error", 64'(internal_error),
        64'(trap_valid && is_fault(trap_cause) && !trap_badaddr_valid));
    if (csr_wr_en && !csr_wr_sel) m_tvec = csr_wr_data;
    if (csr_wr_en && csr_wr_sel) m_epc = csr_wr_data;
    if (trap_valid) begin
      m_epc = trap_pc; m_cause = trap_cause;
      m_tval = exp_tval(trap_cause, trap_badaddr_valid, trap_badaddr, trap_pc);
      m_pie = m_ie; m_ie = 0; m_pp = m_priv; m_priv = 2'b11;
    end else if (ret_valid) begin
      m_ie = m_pie; m_pie = 1; m_priv = (m_pp == 2'b11) ? 2'b11 : 2'b00; m_pp = 2'b00;
    end
    @(negedge clk);
    check_state("R4 R5 R6 R8 R10");
  endtask

  task automatic idle();
    trap_valid = 0; ret_valid = 0; csr_wr_en = 0;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    check_state("R1 reset");

    // R10 write tvec and epc
    csr_wr_en = 1; csr_wr_sel = 0; csr_wr_data = 32'h0000_0100; cycle();
    csr_wr_sel = 1; csr_wr_data = 32'h0000_0200; cycle();
    idle();
    // R2 directed words
    insn = 32'h0000_0073; cycle();
    insn = 32'h3020_0073; cycle();
    insn = 32'h0010_0073; cycle();
    // R8 return from machine to user (MPP=00), then R3 user ecall cause
    ret_valid = 1; cycle(); idle(); cycle();
    // R6 ecall from user clears tval
    trap_valid = 1; trap_cause = 4'd8; trap_pc = 32'h44; trap_badaddr = 32'hdead; trap_badaddr_valid = 1; cycle();
    // R9 both strobes plus R10 epc write overridden by trap
    trap_valid = 1; ret_valid = 1; trap_cause = 4'd3; trap_pc = 32'h88;
    csr_wr_en = 1; csr_wr_sel = 1; csr_wr_data = 32'h1234; cycle();
    // R7 fault without bad address
    idle(); trap_valid = 1; trap_cause = 4'd13; trap_badaddr_valid = 0; cycle();
    idle(); ret_valid = 1; cycle(); cycle(); idle();

    for (int i = 0; i < 400; i++) begin
      trap_valid = ($urandom_range(9) < 3);
      ret_valid = ($urandom_range(9) < 3);
      trap_cause = CW'($urandom_range(15));
      trap_pc = $urandom; trap_badaddr = $urandom;
      trap_badaddr_valid = ($urandom_range(9) < 8);
      csr_wr_en = ($urandom_range(9) < 2);
      csr_wr_sel = $urandom_range(1);
      csr_wr_data = $urandom;
      case ($urandom_range(3))
        0: insn = 32'h0000_0073;
        1: insn = 32'h3020_0073;
        default: insn = $urandom;
      endcase
      cycle();
    end
    idle();
    // R1 reset again after activity
    rst = 1; @(negedge clk); rst = 0; model_reset();
    check_state("R1 re-reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule